// File: doc/BRIEF.md
# Ethernet Receive Frame Validity Checker

This block watches the byte stream a MAC receiver produces once the preamble and start delimiter are gone. For each frame it runs the 32-bit frame check sequence over every byte, the four check bytes included, and counts the frame length. One clock after the last byte it gives a single-cycle verdict that tells the packet buffer to keep or discard the frame, together with a code naming the reason for a discard.

Two configuration pins are captured while reset is held and are then frozen. One raises the length ceiling from 1518 to 1522 bytes so that frames carrying a VLAN tag pass. The other turns off the discard on a bad check sequence. A pin left at 0 gives the plain behaviour: CRC checking on, 1518-byte ceiling.

A small state machine tracks each frame. The states are S_IDLE (waiting for a start byte), S_FRAME (bytes of a frame are arriving) and S_VERDICT (the one cycle in which the verdict is shown). The transitions are: S_IDLE to S_FRAME on a start byte that is not also the last byte. S_IDLE or S_FRAME to S_VERDICT on an accepted last byte. S_FRAME stays in S_FRAME on other bytes; a new start byte there restarts the frame. S_VERDICT to S_FRAME, or back to S_VERDICT for a one-byte frame, when a start byte arrives in that cycle; otherwise S_VERDICT returns to S_IDLE.

Top module: `rxchk_top`

## Requirements
- R1: `out_done` is high for exactly the one cycle after the clock edge that accepts a frame's last byte (`in_valid` and `in_eof` high). In that cycle `out_good` is 1 exactly when `out_cause` is 0. Outside that cycle `out_done` and `out_good` are 0 and `out_cause` is 0. The cause codes are: 0 none, 1 alignment, 2 CRC, 3 short, 4 long.
- R2: A frame counts as having a bad CRC when the CRC-32 over all its bytes, check bytes included, does not leave the residue 0xDEBB20E3. The CRC is reflected (polynomial 0xEDB88320), starts at all ones and takes each byte least-significant bit first. A bad CRC gives cause 2.
- R3: `in_dribble` high with the last byte marks a frame that does not end on a byte boundary, and the verdict is cause 1.
- R4: A frame shorter than 64 bytes, check bytes included, gives cause 3. A frame of exactly 64 bytes is accepted.
- R5: With the VLAN pin latched 0, a frame longer than 1518 bytes gives cause 4. Frames of exactly 1518 bytes are accepted, and so are 1519 to 1522 bytes when the pin is latched 1.
- R6: With the VLAN pin latched 1, the ceiling is 1522 bytes: 1522 bytes is accepted and 1523 bytes gives cause 4.
- R7: With the CRC-disable pin latched 1, a bad CRC is never reported. The frame is accepted unless another error applies.
- R8: Both pins are sampled only while `rst_n` is low. Changing them after reset has no effect on verdicts.
- R9: When several errors apply, the reported cause follows this priority: alignment, then CRC, then short, then long.
- R10: The length count saturates instead of wrapping, so a frame far longer than the ceiling, such as 2100 bytes, still gives cause 4.
- R11: Cycles with `in_valid` low inside a frame add nothing to the CRC or the length. A start byte inside a frame discards what came before it. A start byte in the verdict cycle begins a new frame with no lost byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the configuration pins are sampled while it is low |
| cfg_vlan_len | input | 1 | Configuration pin: 1 raises the length ceiling to 1522 bytes |
| cfg_crc_ignore | input | 1 | Configuration pin: 1 disables the discard on a bad CRC |
| in_valid | input | 1 | A byte is present on `in_data` in this cycle |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | This byte is the first byte of a frame |
| in_eof | input | 1 | This byte is the last byte of a frame |
| in_dribble | input | 1 | Together with the last byte: the frame had extra bits past a byte boundary |
| out_done | output | 1 | Verdict pulse, one cycle after the last byte |
| out_good | output | 1 | The frame passed all checks (high only with `out_done`) |
| out_cause | output | 3 | Discard reason: 0 none, 1 alignment, 2 CRC, 3 short, 4 long |

## Verification
The assertions rely on the following input behaviour:
- `in_sof`, `in_eof` and `in_dribble` are looked at only in cycles where `in_valid` is high.
- `in_dribble` counts only together with a last byte that the block accepts.
- The configuration pins are held steady for at least one cycle of reset.

The stimulus keeps to these rules. Every marker is raised only together with a byte. The pins are set when reset begins, and reset is held for several cycles. The dribble flag is raised only on the last byte and dropped when the frame ends. Check bytes are computed in the bench by a bit-serial CRC so that good frames land exactly on the residue. A corrupted frame flips one payload bit after the CRC has been taken.

// File: rtl/rxchk_pkg.sv
package rxchk_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_ALIGN = 3'd1,
        CAUSE_CRC   = 3'd2,
        CAUSE_SHORT = 3'd3,
        CAUSE_LONG  = 3'd4
    } cause_e;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_FRAME   = 2'd1,
        S_VERDICT = 2'd2
    } state_e;

endpackage

// File: rtl/rxchk_straps.sv
// Captures configuration pins while reset is low and holds them afterwards.
module rxchk_straps #(
    parameter int N_PINS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pins,
    output logic [N_PINS-1:0] held
);

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held[g] <= pins[g];
            end
        end
    end

endmodule

// File: rtl/rxchk_crc.sv
// Running reflected CRC over a byte stream; reports whether the next
// update lands on the good-frame residue.
module rxchk_crc #(
    parameter int           CRC_W   = 32,
    parameter int           DATA_W  = 8,
    parameter logic [31:0]  POLY    = 32'hEDB88320,
    parameter logic [31:0]  INIT    = 32'hFFFFFFFF,
    parameter logic [31:0]  RESIDUE = 32'hDEBB20E3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              step,
    input  logic [DATA_W-1:0] data,
    output logic              residue_ok
);

    localparam logic [CRC_W-1:0] P_POLY = CRC_W'(POLY);
    localparam logic [CRC_W-1:0] P_INIT = CRC_W'(INIT);
    localparam logic [CRC_W-1:0] P_RES  = CRC_W'(RESIDUE);

    logic [CRC_W-1:0] acc_q;
    logic [CRC_W-1:0] base;
    logic [CRC_W-1:0] nxt;

    function automatic logic [CRC_W-1:0] fold(input logic [CRC_W-1:0] c,
                                              input logic [DATA_W-1:0] d);
        logic [CRC_W-1:0] r;
        r = c;
        for (int k = 0; k < DATA_W; k++) begin
            if (r[0] ^ d[k]) begin
                r = (r >> 1) ^ P_POLY;
            end else begin
                r = r >> 1;
            end
        end
        return r;
    endfunction

    always_comb begin
        base       = start ? P_INIT : acc_q;
        nxt        = fold(base, data);
        residue_ok = (nxt == P_RES);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= P_INIT;
        end else if (step) begin
            acc_q <= nxt;
        end
    end

endmodule

// File: rtl/rxchk_len.sv
// Saturating byte counter; len_next is the count including the current byte.
module rxchk_len #(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             step,
    output logic [LEN_W-1:0] len_next
);

    localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] base;

    always_comb begin
        base     = start ? '0 : cnt_q;
        len_next = (base == LEN_MAX) ? LEN_MAX : base + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= len_next;
        end
    end

endmodule

// File: rtl/rxchk_top.sv
module rxchk_top
    import rxchk_pkg::*;
#(
    parameter int MIN_LEN      = 64,
    parameter int MAX_LEN      = 1518,
    parameter int MAX_LEN_VLAN = 1522,
    parameter int LEN_W        = 11,
    parameter int DATA_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_vlan_len,
    input  logic              cfg_crc_ignore,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_dribble,
    output logic              out_done,
    output logic              out_good,
    output logic [2:0]        out_cause
);

    localparam logic [LEN_W-1:0] LIM_MIN  = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] LIM_STD  = LEN_W'(MAX_LEN);
    localparam logic [LEN_W-1:0] LIM_VLAN = LEN_W'(MAX_LEN_VLAN);

    logic [1:0]       pins_held;
    logic             vlan_q;
    logic             crc_off_q;
    logic             start;
    logic             residue_ok;
    logic [LEN_W-1:0] len_nxt;
    logic [LEN_W-1:0] limit;
    logic             eof_hit;
    logic             crc_bad;
    cause_e           cause_d;
    cause_e           cause_q;
    state_e           state_q;
    state_e           state_d;

    rxchk_straps #(.N_PINS(2)) u_straps (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  ({cfg_crc_ignore, cfg_vlan_len}),
        .held  (pins_held)
    );

    assign vlan_q    = pins_held[0];
    assign crc_off_q = pins_held[1];
    assign start     = in_valid && in_sof;

    rxchk_crc #(.DATA_W(DATA_W)) u_crc (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .step       (in_valid),
        .data       (in_data),
        .residue_ok (residue_ok)
    );

    rxchk_len #(.LEN_W(LEN_W)) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .step     (in_valid),
        .len_next (len_nxt)
    );

    // A last byte counts only inside a frame or when it starts one.
    always_comb begin
        eof_hit = in_valid && in_eof && (in_sof || state_q == S_FRAME);
    end

    // Error classification in priority order.
    always_comb begin
        limit   = vlan_q ? LIM_VLAN : LIM_STD;
        crc_bad = !residue_ok && !crc_off_q;
        if (in_dribble) begin
            cause_d = CAUSE_ALIGN;
        end else if (crc_bad) begin
            cause_d = CAUSE_CRC;
        end else if (len_nxt < LIM_MIN) begin
            cause_d = CAUSE_SHORT;
        end else if (len_nxt > limit) begin
            cause_d = CAUSE_LONG;
        end else begin
            cause_d = CAUSE_NONE;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    state_d = in_eof ? S_VERDICT : S_FRAME;
                end
            end
            S_FRAME: begin
                if (in_valid && in_eof) begin
                    state_d = S_VERDICT;
                end
            end
            S_VERDICT: begin
                if (start) begin
                    state_d = in_eof ? S_VERDICT : S_FRAME;
                end else begin
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cause_q <= CAUSE_NONE;
        end else begin
            state_q <= state_d;
            if (eof_hit) begin
                cause_q <= cause_d;
            end
        end
    end

    // Outputs.
    always_comb begin
        out_done  = (state_q == S_VERDICT);
        out_cause = out_done ? cause_q : CAUSE_NONE;
        out_good  = out_done && (cause_q == CAUSE_NONE);
    end

endmodule

// File: rtl/rxchk_sva.sv
module rxchk_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_eof,
    input logic       in_dribble,
    input logic       out_done,
    input logic       out_good,
    input logic [2:0] out_cause,
    input logic       vlan_q,
    input logic       crc_off_q
);

    // R1
    verdict_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> $past(in_valid && in_eof));

    // R1
    cause_code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_cause <= 3'd4);

    // R1
    good_only_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_good |-> out_done && out_cause == 3'd0);

    // R3
    dribble_is_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_done && $past(in_dribble) |-> out_cause == 3'd1);

    // R7
    crc_off_never_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_done && crc_off_q |-> out_cause != 3'd2);

    // R8
    straps_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(vlan_q) && $stable(crc_off_q));

endmodule

bind rxchk_top rxchk_sva u_sva (.*);

// File: tb/sim_rxchk_top.sv
`timescale 1ns/100ps
module sim_rxchk_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_vlan_len = 1'b0;
    logic       cfg_crc_ignore = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_sof = 1'b0;
    logic       in_eof = 1'b0;
    logic       in_dribble = 1'b0;
    logic       out_done;
    logic       out_good;
    logic [2:0] out_cause;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    rxchk_top u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_vlan_len   (cfg_vlan_len),
        .cfg_crc_ignore (cfg_crc_ignore),
        .in_valid       (in_valid),
        .in_data        (in_data),
        .in_sof         (in_sof),
        .in_eof         (in_eof),
        .in_dribble     (in_dribble),
        .out_done       (out_done),
        .out_good       (out_good),
        .out_cause      (out_cause)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Bit-serial reflected CRC-32 step.
    function automatic logic [31:0] crc_bit_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int k = 0; k < 8; k++) begin
            fb = r[0] ^ b[k];
            r  = {1'b0, r[31:1]};
            if (fb) r = r ^ 32'hEDB88320;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual {done,good,cause}=%b expected %b", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic vlan, input logic crcoff);
        rst_n          = 1'b0;
        cfg_vlan_len   = vlan;
        cfg_crc_ignore = crcoff;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Caller is at a negedge. Returns at the negedge where the verdict shows.
    task automatic send_frame(input int len, input bit corrupt, input bit drib,
                              input bit gap, input int seed);
        logic [31:0] crc;
        logic [31:0] fcs;
        logic [7:0]  b;
        crc = 32'hFFFFFFFF;
        fcs = 32'h0;
        for (int i = 0; i < len; i++) begin
            if (gap && (i % 7 == 3)) begin
                in_valid = 1'b0;
                in_sof   = 1'b0;
                @(negedge clk);
            end
            if (i < len - 4) begin
                b   = 8'((i * 37 + seed) & 255);
                crc = crc_bit_step(crc, b);
                if (corrupt && i == 1) b = b ^ 8'h10;
                if (i == len - 5) fcs = ~crc;
            end else begin
                b = 8'(fcs >> (8 * (i - (len - 4))));
            end
            in_valid   = 1'b1;
            in_data    = b;
            in_sof     = (i == 0);
            in_eof     = (i == len - 1);
            in_dribble = drib && (i == len - 1);
            @(negedge clk);
        end
        in_valid   = 1'b0;
        in_sof     = 1'b0;
        in_eof     = 1'b0;
        in_dribble = 1'b0;
    endtask

    task automatic frame_check(input string req, input int len, input bit corrupt,
                               input bit drib, input bit gap, input int exp_cause);
        send_frame(len, corrupt, drib, gap, len);
        check(req, {out_done, out_good, out_cause},
              {1'b1, exp_cause == 0, 3'(exp_cause)});
    endtask

    localparam int NV = 11;
    localparam int V_LEN  [NV] = '{  64,   63, 1518, 1519,  100,  100,   40,   40, 1522, 2100,   30};
    localparam int V_BADC [NV] = '{   0,    0,    0,    0,    1,    0,    1,    1,    0,    0,    0};
    localparam int V_DRIB [NV] = '{   0,    0,    0,    0,    0,    1,    0,    1,    0,    0,    1};
    localparam int V_GAP  [NV] = '{   0,    1,    0,    0,    1,    0,    0,    0,    1,    0,    0};
    localparam int V_EXP  [NV] = '{   0,    3,    0,    4,    2,    1,    2,    1,    4,    4,    1};
    // Rows: 0 R4 boundary good, 1 R4 runt (with R11 gaps), 2 R5 max good,
    // 3 R5 one over, 4 R2 bad CRC, 5 R3 dribble, 6 R9 CRC over short,
    // 7 R9 align over CRC and short, 8 R5 VLAN size rejected, 9 R10 saturating,
    // 10 R9 align over short.

    initial begin
        do_reset(1'b0, 1'b0);
        // R1: reset state, no verdict
        check("R1 reset", {out_done, out_good, out_cause}, 5'b0);

        for (int v = 0; v < NV; v++) begin
            frame_check($sformatf("table row %0d", v), V_LEN[v], V_BADC[v] != 0,
                        V_DRIB[v] != 0, V_GAP[v] != 0, V_EXP[v]);
            @(negedge clk);
            // R1: pulse lasts one cycle
            check("R1 pulse width", {out_done, out_good, out_cause}, 5'b0);
        end

        // R11: start byte in the verdict cycle begins the next frame
        send_frame(80, 1'b0, 1'b0, 1'b0, 3);
        frame_check("R11 back-to-back", 90, 1'b1, 1'b0, 1'b0, 2);

        // R11: start byte inside a frame restarts it
        @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            in_valid = 1'b1; in_data = 8'hA5; in_sof = (i == 0); in_eof = 1'b0;
            @(negedge clk);
        end
        frame_check("R11 restart", 64, 1'b0, 1'b0, 1'b0, 0);

        // R8: pins changed after reset have no effect
        cfg_vlan_len   = 1'b1;
        cfg_crc_ignore = 1'b1;
        @(negedge clk);
        frame_check("R8 vlan pin late", 1520, 1'b0, 1'b0, 1'b0, 4);
        @(negedge clk);
        frame_check("R8 crc pin late", 100, 1'b1, 1'b0, 1'b0, 2);

        // R6: VLAN ceiling
        do_reset(1'b1, 1'b0);
        frame_check("R6 1522 ok", 1522, 1'b0, 1'b0, 1'b0, 0);
        @(negedge clk);
        frame_check("R6 1523 long", 1523, 1'b0, 1'b0, 1'b0, 4);
        @(negedge clk);
        frame_check("R6 bad CRC still reported", 200, 1'b1, 1'b0, 1'b0, 2);

        // R7: CRC discard disabled
        do_reset(1'b0, 1'b1);
        frame_check("R7 bad CRC accepted", 100, 1'b1, 1'b0, 1'b0, 0);
        @(negedge clk);
        frame_check("R7 short still reported", 40, 1'b1, 1'b0, 1'b0, 3);
        @(negedge clk);
        frame_check("R7 long still reported", 1519, 1'b1, 1'b0, 1'b0, 4);
        @(negedge clk);
        frame_check("R7 align still reported", 100, 1'b1, 1'b1, 1'b0, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule